// File: doc/BRIEF.md
# One-Time Program Memory Programming Port

This block is the device-side logic that lets an external programmer write and read back a one-time program memory through a narrow parallel port. The port has no address lines. An internal word address is cleared by a mode command. It then steps forward as the programmer toggles a separate count clock. A 4-bit mode code selects what happens at the current address: address clear, write, verify (read back) or inhibit.

The programmer applies the programming-voltage flag and sets the address to zero. For each word it strobes write mode with the data on the bus and checks the word in verify mode. It then sends four count-clock pulses to move to the next word. The memory is modelled as a behavioural array of 1002 eight-bit words. Every word is all ones after reset. A write can only turn ones into zeros.

The count clock and mode pins are sampled on the system clock. The verify bus and its output enable follow the mode pins combinationally. The address register moves one system clock after the sampled falling edge of the count clock.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the address is 0, the pulse counter is 0, every memory word reads 8'hFF in verify mode, and the bus enable is low.
- R2: With the programming flag high, the mode code (bit 0 is the first mode pin) is decoded as follows. 4'b0101 clears the address. 4'b1110 is write. 4'b1100 is verify. 4'b1101 and 4'b1111 are inhibit. The bus enable is high only in verify.
- R3: The address-clear code sets both the address and the count-clock pulse counter to 0.
- R4: Count-clock falling edges are counted modulo 4. The address rises by one at the falling edge of the third pulse of each group, and the fourth pulse leaves the address unchanged.
- R5: The usable range is 0 to 1001. Advancing from address 1001 wraps to 0, so addresses 1002 to 1023 are never reached.
- R6: Entering write mode produces exactly one write strobe. That strobe stores the old word AND the bus data at the current address. Holding write mode or changing the data afterwards has no effect.
- R7: Codes that are not listed in R2 act as inhibit. Inhibit codes drive no bus, write nothing and leave the address alone, while count pulses are still counted.
- R8: While the programming flag is low, every code acts as inhibit, address clear has no effect, and count pulses are ignored.
- R9: In verify mode the data-out bus carries the word stored at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vpp_ok | input | 1 | Programming voltage present |
| mode | input | 4 | Mode code, bit 0 = first mode pin |
| cnt_clk | input | 1 | Address count clock from the programmer |
| din | input | 8 | Data bus input |
| dout | output | 8 | Data bus output value |
| dout_oe | output | 1 | Data bus output enable (verify only) |
| wr_strobe | output | 1 | One-cycle write strobe to the memory array |
| wr_addr | output | 10 | Current word address |
| wr_data | output | 8 | Value being written (old word AND bus data) |

## Verification
The hardest situation to reach is the wrap from the last usable word back to zero. It needs 1001 full four-pulse groups after a clear, followed by three more pulses. The stimulus writes a marker at address 0 and at address 1001, then drives the long pulse train and reads back across the wrap. The falling edge of the third pulse is observed separately by reading between the third and fourth pulses. A clear issued mid-group tests that the pulse counter resets: two pulses, a clear, then two more pulses must not move the address.

// File: rtl/otp_prog_port.sv
module otp_prog_port #(
  parameter int DW              = 8,
  parameter int AW              = 10,
  parameter int WORDS           = 1002,
  parameter int PULSES_PER_STEP = 4,
  parameter int ADV_PULSE       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_ok,
  input  logic [3:0]    mode,
  input  logic          cnt_clk,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int            PCW      = (PULSES_PER_STEP > 1) ? $clog2(PULSES_PER_STEP) : 1;
  localparam logic [AW-1:0] LAST     = AW'(WORDS - 1);
  localparam logic [PCW-1:0] ADV_AT  = PCW'(ADV_PULSE - 1);
  localparam logic [PCW-1:0] GRP_END = PCW'(PULSES_PER_STEP - 1);
  localparam logic [3:0]    M_CLR    = 4'b0101;
  localparam logic [3:0]    M_WR     = 4'b1110;
  localparam logic [3:0]    M_VFY    = 4'b1100;

  logic [AW-1:0]  addr;
  logic [PCW-1:0] pcnt;
  logic           cclk_q, wr_q;
  logic [DW-1:0]  mem [WORDS];

  wire is_clr = vpp_ok && (mode == M_CLR);
  wire is_wr  = vpp_ok && (mode == M_WR);
  wire is_vfy = vpp_ok && (mode == M_VFY);
  wire fall   = vpp_ok && cclk_q && !cnt_clk;

  wire [DW-1:0] cur_word = mem[addr];

  assign dout      = is_vfy ? cur_word : '0;
  assign dout_oe   = is_vfy;
  assign wr_strobe = is_wr && !wr_q;
  assign wr_addr   = addr;
  assign wr_data   = cur_word & din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      cclk_q <= cnt_clk;
      wr_q   <= is_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      pcnt <= '0;
    end else if (is_clr) begin
      addr <= '0;
      pcnt <= '0;
    end else if (fall) begin
      pcnt <= (pcnt == GRP_END) ? '0 : pcnt + PCW'(1);
      if (pcnt == ADV_AT)
        addr <= (addr == LAST) ? '0 : addr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (wr_strobe) begin
      mem[addr] <= wr_data;
    end
  end

  // R5: the address never enters the reserved range
  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n) addr <= LAST);

  // R3: address clear takes effect on the next edge
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> (addr == '0));

  // R4: the address only moves forward by one or wraps to zero
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (addr == $past(addr) + AW'(1) || addr == '0));

  // R6: a strobe is never repeated on the following cycle
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R6: a write can only clear bits of the addressed word
  p_and_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> (mem[$past(addr)] == ($past(cur_word) & $past(din))));

  // R8: without programming voltage nothing is driven or written, address holds
  p_no_vpp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |-> (!dout_oe && !wr_strobe));
  p_no_vpp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> $stable(addr));

  // R2: the bus enable goes with the verify code only
  p_oe_verify_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (mode == M_VFY));
endmodule

// File: tb/otp_prog_port_tb.sv
module otp_prog_port_tb_top;
  localparam int CLK_P = 10;
  localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110, M_VFY = 4'b1100, M_INH = 4'b1101;

  logic clk = 0, rst_n = 0, vpp_ok = 0, cnt_clk = 0;
  logic [3:0] mode = M_INH;
  logic [7:0] din = '0;
  logic [7:0] dout, wr_data;
  logic       dout_oe, wr_strobe;
  logic [9:0] wr_addr;

  otp_prog_port dut_i (.clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .mode(mode),
    .cnt_clk(cnt_clk), .din(din), .dout(dout), .dout_oe(dout_oe),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { string req; logic oe; logic [7:0] d; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic expect_bus(input string req, input logic oe, input logic [7:0] d);
    item_t it;
    @(posedge clk); #1;
    it.req = req; it.oe = oe; it.d = d;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk); #(CLK_P/4);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (dout_oe !== it.oe || (it.oe && dout !== it.d)) begin
        errors++;
        $display("FAIL %s: oe=%0b dout=%h expected oe=%0b dout=%h", it.req, dout_oe, dout, it.oe, it.d);
      end
    end
  end

  task automatic setmode(input logic [3:0] m);
    @(negedge clk); mode = m;
  endtask

  task automatic pulse();
    @(negedge clk); cnt_clk = 1;
    @(negedge clk); cnt_clk = 0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk); mode = M_WR; din = d;
    @(negedge clk); mode = M_INH;
  endtask

  initial begin
    #(CLK_P*200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_bus("R1 reset bus released", 0, 8'h00);
    vpp_ok = 1;
    setmode(M_VFY); expect_bus("R1 erased word reads FF", 1, 8'hFF);
    setmode(M_CLR); expect_bus("R2 clear code drives no bus", 0, 8'h00);
    setmode(M_INH);

    write_word(8'hA5);
    setmode(M_VFY); expect_bus("R6 first write", 1, 8'hA5);
    setmode(M_WR); din = 8'h0F; expect_bus("R2 write code drives no bus", 0, 8'h00);
    setmode(M_VFY); expect_bus("R6 second write ANDs", 1, 8'h05);

    pulse(); pulse();
    expect_bus("R4 two pulses hold address", 1, 8'h05);
    pulse();
    expect_bus("R4 third fall advances to 1", 1, 8'hFF);
    write_word(8'h3C);
    setmode(M_VFY);
    pulse();
    expect_bus("R4 fourth pulse holds address 1", 1, 8'h3C);
    repeat (4) pulse();
    expect_bus("R9 address 2 reads erased", 1, 8'hFF);

    // R6: held write mode with changing data writes once
    @(negedge clk); mode = M_WR; din = 8'hF0;
    @(negedge clk); din = 8'h0F;
    @(negedge clk); din = 8'h00;
    @(negedge clk); mode = M_VFY;
    expect_bus("R6 held write strobes once", 1, 8'hF0);

    setmode(M_CLR); setmode(M_VFY);
    expect_bus("R3 clear returns to address 0", 1, 8'h05);
    pulse(); pulse();
    setmode(M_CLR); setmode(M_VFY);
    pulse(); pulse();
    expect_bus("R3 clear resets pulse counter", 1, 8'h05);
    setmode(M_CLR); setmode(M_VFY);

    // R7: undefined and inhibit codes
    din = 8'h00;
    setmode(4'b0000); expect_bus("R7 undefined code no bus", 0, 8'h00);
    setmode(4'b1111); expect_bus("R7 inhibit code no bus", 0, 8'h00);
    setmode(4'b0110); expect_bus("R7 undefined code no bus 2", 0, 8'h00);
    setmode(M_VFY); expect_bus("R7 word untouched", 1, 8'h05);
    setmode(M_INH);
    pulse(); pulse(); pulse();
    setmode(M_VFY); expect_bus("R7 pulses counted in inhibit", 1, 8'h3C);
    setmode(M_CLR); setmode(M_VFY);

    // R8: programming flag low
    @(negedge clk); vpp_ok = 0;
    expect_bus("R8 verify ignored without flag", 0, 8'h00);
    write_word(8'h00);
    repeat (4) pulse();
    setmode(M_CLR);
    @(negedge clk); vpp_ok = 1; mode = M_VFY;
    expect_bus("R8 no write, no advance without flag", 1, 8'h05);
    pulse(); pulse(); pulse();
    @(negedge clk); vpp_ok = 0; mode = M_CLR;
    @(negedge clk); vpp_ok = 1; mode = M_VFY;
    expect_bus("R8 clear ignored without flag", 1, 8'h3C);

    // R5: walk to the last word and wrap
    setmode(M_CLR); setmode(M_INH);
    for (int i = 0; i < 1001; i++) begin
      repeat (4) pulse();
    end
    setmode(M_VFY); expect_bus("R5 last word erased", 1, 8'hFF);
    write_word(8'h77);
    setmode(M_VFY); expect_bus("R5 last word written", 1, 8'h77);
    pulse(); pulse(); pulse();
    expect_bus("R5 wrap to address 0", 1, 8'h05);

    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule